// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point operands. Each operand has a sign bit at 31, an 8-bit biased exponent in bits 30:23 and a 23-bit fraction in bits 22:0. A caller presents both operands, an operation select and a rounding mode, and pulses `start` for one cycle. Three clock edges later the block raises `valid` for one cycle. In that cycle it also presents the rounded result and two flags. One new operation can be accepted on every cycle.

Internally the block runs as a three-stage pipeline. The first stage decodes special operands and orders the pair by exponent. It then shifts the smaller significand right, folding the bits it pushes out into a sticky bit. The second stage adds or subtracts the significands. It normalizes on a carry, complements a negative difference, and shifts left by a leading-zero count. The third stage rounds using round and sticky information, renormalizes on a rounding carry, detects overflow and underflow, and packs the result.

Subnormal operands are read as zero of the same sign. Results too small to be normal are flushed to a signed zero.

Top module: `fpadd_unit`

## Requirements
- R1: `valid` is high for exactly one cycle, three rising clock edges after the edge that samples `start` high. Back-to-back starts give back-to-back results in issue order. Reset drives `valid`, `result`, `overflow` and `underflow` to 0.
- R2: When the effective signs match (operand B's sign XOR `op_sub` equals A's sign), the significands are added after aligning the smaller-exponent operand to the larger exponent. A carry out of the sum shifts the result right by one and raises the exponent by one.
- R3: When the effective signs differ, the smaller-exponent significand is subtracted from the other. A negative difference is two's-complemented and flips the result sign. The difference is shifted left by its leading-zero count, and the exponent is lowered by the same count.
- R4: `rnd_mode` 00 rounds to nearest, ties to even. The result is incremented when the round bit and the sticky bit are both 1. On a tie (round bit 1, sticky 0) it is incremented only when the last kept fraction bit is 1.
- R5: `rnd_mode` 01 (toward zero) always truncates the bits below the last kept fraction bit.
- R6: `rnd_mode` 10 (toward +infinity) increments a positive result when the round or sticky bit is set. `rnd_mode` 11 (toward -infinity) does the same for a negative result. Otherwise both modes truncate.
- R7: When rounding carries out of an all-ones significand, the result becomes a fraction of zero with the exponent raised by one.
- R8: If the final exponent reaches 255, the result is infinity with the result sign (exponent 255, fraction 0) and `overflow` is 1.
- R9: Operands with exponent field 0 are treated as zero. A nonzero result whose exponent before rounding is 0 or less is returned as a zero of the result sign, with `underflow` set to 1.
- R10: Any NaN operand (exponent 255, fraction nonzero) gives 0x7FC00000. Infinities of opposite effective sign also give 0x7FC00000. An infinity combined with a finite value gives that infinity, carrying its effective sign. The flags stay 0 for these cases.
- R11: A result that is exactly zero from operands of opposite effective sign is +0 in every mode except mode 11, which gives -0. Two zeros of the same effective sign give a zero of that sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept the operands presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 computes op_a - op_b, 0 computes op_a + op_b |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 32 | Rounded sum or difference |
| overflow | output | 1 | Result overflowed to infinity |
| underflow | output | 1 | Result was flushed to zero |

## Verification
Additions are tried with equal exponents that carry out and with unequal exponents that only align. Subtractions cover a difference that goes negative, and a large gap where a single left shift must draw on the guard bit. Small addends are placed exactly at the halfway point, just above it and just below it, with both signs. These cases separate all four rounding modes, and the tie cases separate an even last bit from an odd one. Further cases distinguish a rounding carry that only renormalizes from one that overflows, a flush to zero from a subnormal input read as zero, NaN from infinity propagation, and the signed-zero rules per rounding mode.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;          // with hidden bit
  localparam int EXT_W  = SIG_W + 3;           // guard, round, sticky
  localparam int EXPI_W = EXP_W + 2;           // internal exponent with sign room
  localparam int LZC_W  = $clog2(EXT_W + 1);

  localparam logic [EXP_W-1:0]  EXP_MAX = '1;
  localparam logic [WORD_W-1:0] QNAN    = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_t;

  typedef struct packed {
    logic              special;
    logic [WORD_W-1:0] spec_word;
    logic              sign_big;
    logic              eff_sub;
    logic [EXP_W-1:0]  exp_big;
    logic [EXT_W-1:0]  sig_big;
    logic [EXT_W-1:0]  sig_small;
    rmode_t            rm;
  } align_t;

  typedef struct packed {
    logic              special;
    logic [WORD_W-1:0] spec_word;
    logic              sign;
    logic              zero;
    logic [EXPI_W-1:0] exp;
    logic [EXT_W-1:0]  sig;
    rmode_t            rm;
  } norm_t;

  // Right shift by d; everything pushed out is ORed into bit 0.
  function automatic logic [EXT_W-1:0] shift_sticky(input logic [EXT_W-1:0] v,
                                                    input logic [EXP_W-1:0] d);
    logic [EXT_W-1:0] mask;
    logic [EXT_W-1:0] res;
    if (d >= EXP_W'(EXT_W)) begin
      res    = '0;
      res[0] = |v;
    end else begin
      mask   = ~({EXT_W{1'b1}} << d);
      res    = v >> d;
      res[0] = res[0] | (|(v & mask));
    end
    return res;
  endfunction

  function automatic logic [LZC_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
    logic [LZC_W-1:0] n;
    logic             found;
    n     = '0;
    found = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (v[i]) found = 1'b1;
        else      n = n + 1'b1;
      end
    end
    return n;
  endfunction

  function automatic logic round_up(input rmode_t rm, input logic sign,
                                    input logic lsb, input logic rb, input logic sb);
    case (rm)
      RM_NEAR: return rb & (sb | lsb);
      RM_ZERO: return 1'b0;
      RM_UP:   return ~sign & (rb | sb);
      default: return sign & (rb | sb);
    endcase
  endfunction

endpackage

// File: rtl/fpadd_prep.sv
module fpadd_prep
  import fpadd_pkg::*;
(
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              op_sub,
  input  rmode_t            rm,
  output align_t            stage
);

  logic             sa, sb;
  logic [EXP_W-1:0] ea, eb, dexp;
  logic [FRAC_W-1:0] fa, fb;
  logic             a_nan, b_nan, a_inf, b_inf, swap_ops;
  logic [EXT_W-1:0] siga, sigb, small_raw;

  assign sa = op_a[WORD_W-1];
  assign sb = op_b[WORD_W-1] ^ op_sub;
  assign ea = op_a[WORD_W-2 -: EXP_W];
  assign eb = op_b[WORD_W-2 -: EXP_W];
  assign fa = op_a[FRAC_W-1:0];
  assign fb = op_b[FRAC_W-1:0];

  assign a_nan = (ea == EXP_MAX) && (fa != '0);
  assign b_nan = (eb == EXP_MAX) && (fb != '0);
  assign a_inf = (ea == EXP_MAX) && (fa == '0);
  assign b_inf = (eb == EXP_MAX) && (fb == '0);

  // exponent field 0 reads as zero (subnormals flushed on input)
  assign siga = (ea != '0) ? {1'b1, fa, 3'b000} : '0;
  assign sigb = (eb != '0) ? {1'b1, fb, 3'b000} : '0;

  assign swap_ops = eb > ea;

  always_comb begin
    stage           = '0;
    stage.rm        = rm;
    stage.eff_sub   = sa ^ sb;
    stage.sign_big  = swap_ops ? sb : sa;
    stage.exp_big   = swap_ops ? eb : ea;
    stage.sig_big   = swap_ops ? sigb : siga;
    small_raw       = swap_ops ? siga : sigb;
    dexp            = swap_ops ? (eb - ea) : (ea - eb);
    stage.sig_small = shift_sticky(small_raw, dexp);
    if (a_nan || b_nan || (a_inf && b_inf && (sa != sb))) begin
      stage.special   = 1'b1;
      stage.spec_word = QNAN;
    end else if (a_inf) begin
      stage.special   = 1'b1;
      stage.spec_word = {sa, EXP_MAX, {FRAC_W{1'b0}}};
    end else if (b_inf) begin
      stage.special   = 1'b1;
      stage.spec_word = {sb, EXP_MAX, {FRAC_W{1'b0}}};
    end
  end

endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
(
  input  align_t           stage,
  output norm_t            res,
  output logic             sum_carry,
  output logic             diff_neg,
  output logic [LZC_W-1:0] lz_count
);

  logic [EXT_W:0]   sum, diff;
  logic [EXT_W-1:0] mag;

  always_comb begin
    sum       = {1'b0, stage.sig_big} + {1'b0, stage.sig_small};
    diff      = {1'b0, stage.sig_big} - {1'b0, stage.sig_small};
    mag       = diff[EXT_W] ? (~diff[EXT_W-1:0] + 1'b1) : diff[EXT_W-1:0];
    sum_carry = ~stage.eff_sub & sum[EXT_W];
    diff_neg  = stage.eff_sub & diff[EXT_W];
    lz_count  = lead_zeros(mag);

    res           = '0;
    res.special   = stage.special;
    res.spec_word = stage.spec_word;
    res.rm        = stage.rm;

    if (!stage.eff_sub) begin
      res.sign = stage.sign_big;
      res.zero = (sum == '0);
      if (sum[EXT_W]) begin
        res.sig    = sum[EXT_W:1];
        res.sig[0] = sum[1] | sum[0];
        res.exp    = {2'b00, stage.exp_big} + EXPI_W'(1);
      end else begin
        res.sig = sum[EXT_W-1:0];
        res.exp = {2'b00, stage.exp_big};
      end
    end else begin
      res.zero = (mag == '0);
      res.sign = res.zero ? (stage.rm == RM_DOWN) : (stage.sign_big ^ diff[EXT_W]);
      res.sig  = mag << lz_count;
      res.exp  = {2'b00, stage.exp_big} - EXPI_W'(lz_count);
    end
  end

endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  norm_t             res,
  output logic [WORD_W-1:0] word,
  output logic              ovf,
  output logic              unf,
  output logic              inc,
  output logic              renorm
);

  logic [SIG_W:0]    rsum;
  logic [EXPI_W-1:0] efin;
  logic [FRAC_W-1:0] frac;
  logic              lsb, rbit, sbit;

  always_comb begin
    lsb    = res.sig[3];
    rbit   = res.sig[2];
    sbit   = |res.sig[1:0];
    inc    = round_up(res.rm, res.sign, lsb, rbit, sbit);
    rsum   = {1'b0, res.sig[EXT_W-1:3]} + (SIG_W+1)'(inc);
    renorm = rsum[SIG_W];
    efin   = res.exp + EXPI_W'(renorm);
    frac   = renorm ? rsum[FRAC_W:1] : rsum[FRAC_W-1:0];

    word = '0;
    ovf  = 1'b0;
    unf  = 1'b0;
    if (res.special) begin
      word = res.spec_word;
    end else if (res.zero) begin
      word = {res.sign, {(WORD_W-1){1'b0}}};
    end else if (res.exp[EXPI_W-1] || (res.exp == '0)) begin
      word = {res.sign, {(WORD_W-1){1'b0}}};
      unf  = 1'b1;
    end else if (efin >= EXPI_W'(EXP_MAX)) begin
      word = {res.sign, EXP_MAX, {FRAC_W{1'b0}}};
      ovf  = 1'b1;
    end else begin
      word = {res.sign, efin[EXP_W-1:0], frac};
    end
  end

endmodule

// File: rtl/fpadd_unit.sv
module fpadd_unit
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              op_sub,
  input  logic [1:0]        rnd_mode,
  output logic              valid,
  output logic [WORD_W-1:0] result,
  output logic              overflow,
  output logic              underflow
);

  align_t            prep_out, s1_q;
  norm_t             norm_out, s2_q;
  logic              v1_q, v2_q;
  logic              sum_carry, diff_neg, rnd_inc, rnd_renorm, rnd_ovf, rnd_unf;
  logic [LZC_W-1:0]  lz_count;
  logic [WORD_W-1:0] rnd_word;

  fpadd_prep u_prep (
    .op_a  (op_a),
    .op_b  (op_b),
    .op_sub(op_sub),
    .rm    (rmode_t'(rnd_mode)),
    .stage (prep_out)
  );

  fpadd_norm u_norm (
    .stage    (s1_q),
    .res      (norm_out),
    .sum_carry(sum_carry),
    .diff_neg (diff_neg),
    .lz_count (lz_count)
  );

  fpadd_round u_round (
    .res   (s2_q),
    .word  (rnd_word),
    .ovf   (rnd_ovf),
    .unf   (rnd_unf),
    .inc   (rnd_inc),
    .renorm(rnd_renorm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q      <= 1'b0;
      v2_q      <= 1'b0;
      valid     <= 1'b0;
      s1_q      <= '0;
      s2_q      <= '0;
      result    <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      v1_q  <= start;
      v2_q  <= v1_q;
      valid <= v2_q;
      s1_q  <= prep_out;
      s2_q  <= norm_out;
      if (v2_q) begin
        result    <= rnd_word;
        overflow  <= rnd_ovf;
        underflow <= rnd_unf;
      end
    end
  end

  // ---- stage 1: alignment keeps the larger exponent (R2)
  assert_align_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (prep_out.exp_big >= op_a[WORD_W-2 -: EXP_W]) &&
              (prep_out.exp_big >= op_b[WORD_W-2 -: EXP_W]));

  // ---- stage 2: normalization
  assert_carry_exp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && sum_carry && !s1_q.special) |-> (norm_out.exp == {2'b00, s1_q.exp_big} + EXPI_W'(1)));

  assert_negdiff_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && diff_neg && !s1_q.special) |-> (norm_out.sign != s1_q.sign_big));

  assert_norm_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && !s1_q.special && !norm_out.zero) |-> norm_out.sig[EXT_W-1]);

  // a shift of two or more only follows a near-exponent subtraction, which loses nothing
  assert_lz_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && s1_q.eff_sub && !s1_q.special && (lz_count > LZC_W'(1))) |-> (norm_out.sig[1:0] == 2'b00));

  // ---- stage 3: rounding and packing
  assert_rtz_noinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && (s2_q.rm == RM_ZERO)) |-> !rnd_inc);

  assert_round_renorm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && rnd_renorm && !s2_q.special && !s2_q.zero && !rnd_ovf && !rnd_unf)
      |-> (rnd_word[FRAC_W-1:0] == '0));

  // ---- outputs
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(start, 3));

  assert_ovf_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && overflow) |-> (result[WORD_W-2:0] == {EXP_MAX, {FRAC_W{1'b0}}}));

  assert_unf_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && underflow) |-> (result[WORD_W-2:0] == '0) && !overflow);

endmodule

// File: tb/fpadd_unit_tb.sv
module fpadd_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        op_sub = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        valid;
  logic [31:0] result;
  logic        overflow, underflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fpadd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .rnd_mode(rnd_mode), .valid(valid), .result(result),
    .overflow(overflow), .underflow(underflow)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        sub;
    logic [1:0]  rm;
    logic [31:0] res;
    logic        ovf;
    logic        unf;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{32'h3F800000, 32'h3F800000, 1'b0, 2'd0, 32'h40000000, 1'b0, 1'b0, 8'd2},  // R2 carry
    '{32'h3FC00000, 32'h3FC00000, 1'b0, 2'd0, 32'h40400000, 1'b0, 1'b0, 8'd2},  // R2
    '{32'h3F800000, 32'h3F000000, 1'b0, 2'd0, 32'h3FC00000, 1'b0, 1'b0, 8'd2},  // R2 align
    '{32'h40800000, 32'h3F800000, 1'b1, 2'd0, 32'h40400000, 1'b0, 1'b0, 8'd3},  // R3 gap 2
    '{32'h3F800000, 32'h3FC00000, 1'b1, 2'd0, 32'hBF000000, 1'b0, 1'b0, 8'd3},  // R3 negative
    '{32'h3FC00000, 32'hC0400000, 1'b0, 2'd0, 32'hBFC00000, 1'b0, 1'b0, 8'd3},  // R3 swapped
    '{32'h3F800000, 32'h33800000, 1'b0, 2'd0, 32'h3F800000, 1'b0, 1'b0, 8'd4},  // R4 tie even
    '{32'h3F800001, 32'h33800000, 1'b0, 2'd0, 32'h3F800002, 1'b0, 1'b0, 8'd4},  // R4 tie odd
    '{32'h3F800000, 32'h33C00000, 1'b0, 2'd0, 32'h3F800001, 1'b0, 1'b0, 8'd4},  // R4 above half
    '{32'h3F800000, 32'h33000000, 1'b0, 2'd0, 32'h3F800000, 1'b0, 1'b0, 8'd4},  // R4 below half
    '{32'h3F800000, 32'h33C00000, 1'b0, 2'd1, 32'h3F800000, 1'b0, 1'b0, 8'd5},  // R5
    '{32'hBF800000, 32'hB3C00000, 1'b0, 2'd1, 32'hBF800000, 1'b0, 1'b0, 8'd5},  // R5 negative
    '{32'h3F800000, 32'h33000000, 1'b0, 2'd2, 32'h3F800001, 1'b0, 1'b0, 8'd6},  // R6 up, positive
    '{32'hBF800000, 32'hB3000000, 1'b0, 2'd2, 32'hBF800000, 1'b0, 1'b0, 8'd6},  // R6 up, negative
    '{32'hBF800000, 32'hB3000000, 1'b0, 2'd3, 32'hBF800001, 1'b0, 1'b0, 8'd6},  // R6 down, negative
    '{32'h3F800000, 32'h33000000, 1'b0, 2'd3, 32'h3F800000, 1'b0, 1'b0, 8'd6},  // R6 down, positive
    '{32'h3F800000, 32'h33000000, 1'b1, 2'd0, 32'h3F800000, 1'b0, 1'b0, 8'd7},  // R7 carry renorm
    '{32'h3F800000, 32'h33000000, 1'b1, 2'd1, 32'h3F7FFFFF, 1'b0, 1'b0, 8'd5},  // R5
    '{32'h3F800000, 32'h33000000, 1'b1, 2'd3, 32'h3F7FFFFF, 1'b0, 1'b0, 8'd6},  // R6
    '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd0, 32'h7F800000, 1'b1, 1'b0, 8'd8},  // R8
    '{32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 2'd0, 32'hFF800000, 1'b1, 1'b0, 8'd8},  // R8 negative
    '{32'h7F7FFFFF, 32'h73000000, 1'b0, 2'd0, 32'h7F800000, 1'b1, 1'b0, 8'd8},  // R8 via rounding
    '{32'h7F7FFFFF, 32'h73000000, 1'b0, 2'd1, 32'h7F7FFFFF, 1'b0, 1'b0, 8'd5},  // R5 no overflow
    '{32'h00800001, 32'h00800000, 1'b1, 2'd0, 32'h00000000, 1'b0, 1'b1, 8'd9},  // R9 flush
    '{32'h3F800000, 32'h00000001, 1'b0, 2'd0, 32'h3F800000, 1'b0, 1'b0, 8'd9},  // R9 subnormal in
    '{32'h00000001, 32'h00000001, 1'b0, 2'd0, 32'h00000000, 1'b0, 1'b0, 8'd9},  // R9
    '{32'h7FC00001, 32'h3F800000, 1'b0, 2'd0, 32'h7FC00000, 1'b0, 1'b0, 8'd10}, // R10 NaN
    '{32'h7F800000, 32'h7F800000, 1'b1, 2'd0, 32'h7FC00000, 1'b0, 1'b0, 8'd10}, // R10 inf-inf
    '{32'h7F800000, 32'hFF800000, 1'b0, 2'd0, 32'h7FC00000, 1'b0, 1'b0, 8'd10}, // R10
    '{32'h7F800000, 32'h3F800000, 1'b0, 2'd0, 32'h7F800000, 1'b0, 1'b0, 8'd10}, // R10 inf+x
    '{32'h3F800000, 32'h7F800000, 1'b1, 2'd0, 32'hFF800000, 1'b0, 1'b0, 8'd10}, // R10 x-inf
    '{32'h3F800000, 32'h3F800000, 1'b1, 2'd0, 32'h00000000, 1'b0, 1'b0, 8'd11}, // R11
    '{32'h3F800000, 32'h3F800000, 1'b1, 2'd3, 32'h80000000, 1'b0, 1'b0, 8'd11}, // R11 down
    '{32'h00000000, 32'h80000000, 1'b0, 2'd3, 32'h80000000, 1'b0, 1'b0, 8'd11}, // R11
    '{32'h80000000, 32'h80000000, 1'b0, 2'd0, 32'h80000000, 1'b0, 1'b0, 8'd11}, // R11 same sign
    '{32'h00000000, 32'h80000000, 1'b0, 2'd2, 32'h00000000, 1'b0, 1'b0, 8'd11}  // R11 up
  };

  task automatic check(input string tag, input logic [33:0] got, input logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input logic [1:0] rm, output int lat);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = s; rnd_mode = rm; start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!valid && lat < 20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {valid, overflow, underflow, result[30:0]}, 34'd0);
    check("R1 reset result", {2'b00, result}, 34'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 latency
    issue(32'h3F800000, 32'h3F800000, 1'b0, 2'd0, lat);
    check("R1 latency", 34'(lat), 34'd3);
    @(negedge clk);
    check("R1 single pulse", {33'd0, valid}, 34'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].a, VECS[i].b, VECS[i].sub, VECS[i].rm, lat);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            {result, overflow, underflow}, {VECS[i].res, VECS[i].ovf, VECS[i].unf});
    end

    // R1 back-to-back issue, results in order on consecutive cycles
    @(negedge clk);
    op_a = 32'h3F800000; op_b = 32'h3F000000; op_sub = 1'b0; rnd_mode = 2'd0; start = 1'b1;
    @(negedge clk);
    op_a = 32'h40800000; op_b = 32'h3F800000; op_sub = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R1 back-to-back first", {valid, result, 1'b0}, {1'b1, 32'h3FC00000, 1'b0});
    @(negedge clk);
    check("R1 back-to-back second", {valid, result, 1'b0}, {1'b1, 32'h40400000, 1'b0});
    @(negedge clk);
    check("R1 pulse ends", {33'd0, valid}, 34'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule